// File: doc/BRIEF.md
# Boot Source Selector with Mode Blink Code

This block picks the boot source of a processing system from two board switches and two card-detect lines. It drives a 4-bit boot mode bus, an SD select line and a copy of the micro-SD detect for the FPGA. It also produces a single-bit `blink_o` that shows the chosen source on a status LED. A detected micro-SD card always wins over the switches. When both switches are on, the block uses an eMMC device if one is present and otherwise falls back to SPI flash. A build option can forbid that fallback and flag an error in its place.

All four inputs come from slow, asynchronous board signals, so each one passes through a synchroniser before decoding. The blink code splits a period of a free-running counter into eight equal slots. The mode is shown by how many slots, counted from the start of the period, are lit. The error condition instead toggles the LED eight times faster. At the default counter width of 25 bits and a 24.576 MHz clock, the period is about 0.73 Hz and the error toggle is about 5.86 Hz.

Top module: `boot_mode_selector`

## Requirements
- R1: While reset is asserted, `mode_o` is 4'h0, and `sd_sel_o`, `sd_cd_o` and `blink_o` are 0.
- R2: With both switches on (`sw1_i` = 1 and `sw2_i` = 1), no micro-SD card (`usd_det_i` = 0) and `mmc_det_i` = 1, `mode_o` is 4'h6 (eMMC).
- R3: With both switches on and neither card detected, `mode_o` is 4'h2 (SPI flash). This holds whether or not the fallback is allowed.
- R4: `sw1_i` = 0 with `sw2_i` = 1 gives 4'h1 (PJTAG0), `sw1_i` = 1 with `sw2_i` = 0 gives 4'h6 (eMMC), and both 0 gives 4'h0 (main JTAG). No code other than 4'h0, 4'h1, 4'h2, 4'h3 and 4'h6 ever appears.
- R5: `usd_det_i` = 1 gives `mode_o` = 4'h3 (SD) for every switch setting. `sd_sel_o` is 1 exactly when `mode_o` is 4'h3.
- R6: `sd_cd_o` follows `usd_det_i` after synchronisation.
- R7: A change on any input shows on `mode_o`, `sd_sel_o` and `sd_cd_o` on the (SYNC_STAGES+1)-th rising edge after it, and not earlier.
- R8: When no error is flagged, each period of 2^CNT_W cycles holds one lit run starting at the period start. The run spans 5 slots for JTAG, 4 for PJTAG0, 3 for eMMC, 2 for SPI and 1 for SD, each slot being 2^(CNT_W-3) cycles.
- R9: With SPI_FALLBACK = 0, both switches on and no card detected, `blink_o` follows counter bit CNT_W-4. That gives 8 equal high pulses per period, 50 % duty.
- R10: `mmc_det_i` has no effect unless both switches are on and no micro-SD card is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw1_i | input | 1 | Boot switch 1, 1 = on |
| sw2_i | input | 1 | Boot switch 2, 1 = on |
| usd_det_i | input | 1 | Micro-SD card present, 1 = present |
| mmc_det_i | input | 1 | eMMC/SD device present, 1 = present |
| mode_o | output | 4 | Boot mode code |
| sd_sel_o | output | 1 | High when SD boot is chosen |
| sd_cd_o | output | 1 | Synchronised micro-SD detect for the FPGA |
| blink_o | output | 1 | Mode blink code for a status LED |

## Verification
The bench goes after the micro-SD override under all four switch settings. A design that let the switches win would report a JTAG or eMMC code with SD select low. It also toggles `mmc_det_i` outside the default setting, which catches a decoder that leaks the detect into the PJTAG0 or JTAG cases. It measures a whole blink period per mode, counting lit cycles and rising edges, so a wrong slot count, a lit run off the period start or a missing error toggle shows as a wrong total. It also times the synchroniser edge by edge, which exposes a stage too few or too many.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

    typedef enum logic [3:0] {
        MODE_JTAG  = 4'h0,
        MODE_PJTAG = 4'h1,
        MODE_SPI   = 4'h2,
        MODE_SD    = 4'h3,
        MODE_EMMC  = 4'h6
    } boot_mode_e;

    typedef struct packed {
        boot_mode_e mode;
        logic       sd_sel;
        logic       sd_cd;
    } sel_state_t;

    // Number of lit slots (out of 8) that identifies each mode.
    function automatic logic [3:0] lit_slots(boot_mode_e m);
        case (m)
            MODE_JTAG:  return 4'd5;
            MODE_PJTAG: return 4'd4;
            MODE_EMMC:  return 4'd3;
            MODE_SPI:   return 4'd2;
            MODE_SD:    return 4'd1;
            default:    return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/bootsel_sync.sv
module bootsel_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_comb stage_d[g] = async_i;
            end else begin : g_next
                always_comb stage_d[g] = stage_q[g-1];
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[g] <= '0;
                else         stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/bootsel_decode.sv
module bootsel_decode
    import boot_sel_pkg::*;
#(
    parameter bit SPI_FALLBACK = 1'b1
) (
    input  logic       sw1_on_i,
    input  logic       sw2_on_i,
    input  logic       usd_i,
    input  logic       mmc_i,
    output boot_mode_e mode_o,
    output logic       err_o,
    output logic [3:0] lit_o
);

    always_comb begin
        err_o  = 1'b0;
        mode_o = MODE_JTAG;
        if (usd_i) begin
            mode_o = MODE_SD;
        end else begin
            unique case ({sw1_on_i, sw2_on_i})
                2'b11: begin
                    if (mmc_i) begin
                        mode_o = MODE_EMMC;
                    end else begin
                        mode_o = MODE_SPI;
                        err_o  = !SPI_FALLBACK;
                    end
                end
                2'b01:   mode_o = MODE_PJTAG;
                2'b10:   mode_o = MODE_EMMC;
                default: mode_o = MODE_JTAG;
            endcase
        end
        lit_o = lit_slots(mode_o);
    end

endmodule

// File: rtl/bootsel_blink.sv
module bootsel_blink #(
    parameter int CNT_W = 25
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       err_i,
    input  logic [3:0] lit_i,
    output logic       blink_o
);

    localparam int                 ERR_BIT = CNT_W - 4;
    localparam logic [CNT_W-1:0]   ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             blink;
    } blink_state_t;

    blink_state_t st_d, st_q;
    logic [2:0]   slot_idx;

    assign slot_idx = st_q.cnt[CNT_W-1 -: 3];

    always_comb begin
        st_d.cnt   = st_q.cnt + ONE;
        st_d.blink = err_i ? st_q.cnt[ERR_BIT] : ({1'b0, slot_idx} < lit_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign blink_o = st_q.blink;

    // R8: the slot counter advances by exactly one every cycle.
    assert_cnt_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> st_q.cnt == $past(st_q.cnt) + ONE);

    // R8: a non-error mode always asks for between one and five lit slots.
    assert_lit_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !err_i |-> (lit_i >= 4'd1 && lit_i <= 4'd5));

endmodule

// File: rtl/boot_mode_selector.sv
module boot_mode_selector
    import boot_sel_pkg::*;
#(
    parameter int CNT_W        = 25,
    parameter int SYNC_STAGES  = 2,
    parameter bit SPI_FALLBACK = 1'b1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       sw1_i,
    input  logic       sw2_i,
    input  logic       usd_det_i,
    input  logic       mmc_det_i,
    output logic [3:0] mode_o,
    output logic       sd_sel_o,
    output logic       sd_cd_o,
    output logic       blink_o
);

    localparam int N_IN = 4;

    logic [N_IN-1:0] raw_in, sync_in;
    logic            sw1_s, sw2_s, usd_s, mmc_s;
    boot_mode_e      mode_sel;
    logic            err_sel;
    logic [3:0]      lit_sel;
    sel_state_t      st_d, st_q;

    assign raw_in = {sw1_i, sw2_i, usd_det_i, mmc_det_i};
    assign {sw1_s, sw2_s, usd_s, mmc_s} = sync_in;

    bootsel_sync #(
        .WIDTH  (N_IN),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    bootsel_decode #(
        .SPI_FALLBACK (SPI_FALLBACK)
    ) i_decode (
        .sw1_on_i (sw1_s),
        .sw2_on_i (sw2_s),
        .usd_i    (usd_s),
        .mmc_i    (mmc_s),
        .mode_o   (mode_sel),
        .err_o    (err_sel),
        .lit_o    (lit_sel)
    );

    bootsel_blink #(
        .CNT_W (CNT_W)
    ) i_blink (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .err_i   (err_sel),
        .lit_i   (lit_sel),
        .blink_o (blink_o)
    );

    always_comb begin
        st_d.mode   = mode_sel;
        st_d.sd_sel = (mode_sel == MODE_SD);
        st_d.sd_cd  = usd_s;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{mode: MODE_JTAG, sd_sel: 1'b0, sd_cd: 1'b0};
        else         st_q <= st_d;
    end

    assign mode_o   = st_q.mode;
    assign sd_sel_o = st_q.sd_sel;
    assign sd_cd_o  = st_q.sd_cd;

    // R5: a synchronised micro-SD detect forces SD boot on the next edge.
    assert_usd_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        usd_s |=> (mode_o == 4'h3 && sd_sel_o));

    // R5: SD select never rises without the SD code on the mode bus.
    assert_sel_only_sd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sd_sel_o |-> mode_o == 4'h3);

    // R6: the card-detect output is the synchronised detect one edge later.
    assert_cd_mirror_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> sd_cd_o == $past(usd_s));

    // R4: only the five defined codes reach the mode bus.
    assert_mode_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_o inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h6});

    // R4: both switches off with no micro-SD card gives main JTAG.
    assert_jtag_switches_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!usd_s && !sw1_s && !sw2_s) |=> mode_o == 4'h0);

endmodule

// File: tb/test_boot_mode_selector.sv
module test_boot_mode_selector;

    localparam int CNT_W  = 8;
    localparam int SYNC   = 2;
    localparam int PERIOD = 1 << CNT_W;
    localparam int SLOT   = 1 << (CNT_W - 3);

    logic clk = 1'b0;
    logic rst_n;
    logic sw1, sw2, usd, mmc;
    logic [3:0] mode_a, mode_b;
    logic sel_a, sel_b, cd_a, cd_b, blink_a, blink_b;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #4 clk = ~clk;

    boot_mode_selector #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC), .SPI_FALLBACK(1'b1)) i_boot_mode_selector (
        .clk_i(clk), .rst_ni(rst_n), .sw1_i(sw1), .sw2_i(sw2), .usd_det_i(usd), .mmc_det_i(mmc),
        .mode_o(mode_a), .sd_sel_o(sel_a), .sd_cd_o(cd_a), .blink_o(blink_a));

    boot_mode_selector #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC), .SPI_FALLBACK(1'b0)) i_boot_mode_selector_strict (
        .clk_i(clk), .rst_ni(rst_n), .sw1_i(sw1), .sw2_i(sw2), .usd_det_i(usd), .mmc_det_i(mmc),
        .mode_o(mode_b), .sd_sel_o(sel_b), .sd_cd_o(cd_b), .blink_o(blink_b));

    function automatic int exp_mode(bit s1, bit s2, bit u, bit m);
        if (u) return 3;
        case ({s1, s2})
            2'b11:   return m ? 6 : 2;
            2'b01:   return 1;
            2'b10:   return 6;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_err(bit s1, bit s2, bit u, bit m, bit fb);
        return !u && s1 && s2 && !m && !fb;
    endfunction

    function automatic int exp_lit(int md);
        case (md)
            0: return 5;
            1: return 4;
            6: return 3;
            2: return 2;
            3: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(bit s1, bit s2, bit u, bit m);
        @(negedge clk);
        sw1 = s1; sw2 = s2; usd = u; mmc = m;
    endtask

    task automatic check_outputs(string req, bit s1, bit s2, bit u, bit m);
        int md = exp_mode(s1, s2, u, m);
        check({req, " mode"},       mode_a, md);
        check({req, " mode strict"}, mode_b, md);
        check({req, " R5 sd_sel"},  sel_a,  (md == 3) ? 1 : 0);
        check({req, " R5 sd_sel strict"}, sel_b, (md == 3) ? 1 : 0);
        check({req, " R6 sd_cd"},   cd_a,   u);
        check({req, " R6 sd_cd strict"}, cd_b, u);
    endtask

    // One period of samples: lit cycles and rising edges for both instances.
    task automatic check_blink(string req, bit s1, bit s2, bit u, bit m);
        int hi_a = 0, hi_b = 0, up_a = 0, up_b = 0;
        logic pa = blink_a, pb = blink_b;
        int md = exp_mode(s1, s2, u, m);
        for (int i = 0; i < PERIOD; i++) begin
            @(negedge clk);
            if (blink_a) hi_a++;
            if (blink_b) hi_b++;
            if (blink_a && !pa) up_a++;
            if (blink_b && !pb) up_b++;
            pa = blink_a;
            pb = blink_b;
        end
        check({req, " R8 lit cycles"}, hi_a, exp_lit(md) * SLOT);
        check({req, " R8 rises"},      up_a, 1);
        if (exp_err(s1, s2, u, m, 1'b0)) begin
            check({req, " R9 error high cycles"}, hi_b, PERIOD / 2);
            check({req, " R9 error rises"},       up_b, 8);
        end else begin
            check({req, " R8 lit cycles strict"}, hi_b, exp_lit(md) * SLOT);
            check({req, " R8 rises strict"},      up_b, 1);
        end
    endtask

    task automatic apply(string req, bit s1, bit s2, bit u, bit m, bit do_blink);
        drive(s1, s2, u, m);
        repeat (SYNC + 2) @(negedge clk);
        check_outputs(req, s1, s2, u, m);
        if (do_blink) check_blink(req, s1, s2, u, m);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        rst_n = 1'b0;
        sw1 = 1'b1; sw2 = 1'b1; usd = 1'b1; mmc = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset mode",   mode_a, 0);
        check("R1 reset sd_sel", sel_a, 0);
        check("R1 reset sd_cd",  cd_a, 0);
        check("R1 reset blink",  blink_a, 0);
        check("R1 reset blink strict", blink_b, 0);
        sw1 = 1'b0; sw2 = 1'b0; usd = 1'b0; mmc = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        apply("R4 both off",            1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        apply("R4 pjtag",               1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        apply("R4 emmc switch",         1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        apply("R2 default emmc",        1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        apply("R3 R9 default no card",  1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        apply("R5 usd default",         1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        apply("R5 usd both off",        1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        apply("R5 usd pjtag",           1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        apply("R5 usd emmc switch",     1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        apply("R10 mmc in pjtag",       1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        apply("R10 mmc in jtag",        1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        apply("R10 mmc in emmc switch", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);

        // R7: from JTAG, a micro-SD detect must not show before edge SYNC+1.
        apply("R7 setup", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b1, 1'b0);
        repeat (SYNC) @(negedge clk);
        check("R7 mode early",  mode_a, 0);
        check("R7 sd_cd early", cd_a, 0);
        @(negedge clk);
        check("R7 mode on time",  mode_a, 3);
        check("R7 sd_cd on time", cd_a, 1);

        void'($urandom(32'h5EED_B007));
        for (int v = 0; v < 24; v++) begin
            int r = $urandom;
            apply("R2 R3 R4 R5 R6 R10 random", r[0], r[1], r[2] & r[5], r[3], (v % 4) == 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule